// File: doc/BRIEF.md
# Completion Timeout Tracker

This block watches the non-posted requests a requester sends out and reports any that never get an answer. Each request that expects a completion loads a per-tag countdown. A matching completion stops that countdown. If the countdown runs out first, the block produces a synthetic error completion descriptor on a valid/ready output stream, in the same place a real completion would be reported. The countdowns advance on a shared prescaler tick, so the programmed periods are counted in ticks.

Whether timers run at all depends on a 4-bit range field. Only two codes arm the mechanism, and each takes its period from its own programmable register. Every other code leaves the tracker inert. A disable bit can switch the mechanism off, but only when a capability strap allows it. Configuration requests are never timed.

Top module: `cpl_timeout_tracker`

## Requirements
- R1: A request with `req_type` = 2'd2 (configuration) never starts a timer and never produces a report. Other types (0, 1, 3) are tracked.
- R2: With `cto_range` = 4'b0101 at the time of the request, the report for that tag appears more than (N-1)·PRESCALE and at most N·PRESCALE cycles after the request is accepted, where N = `tmo_val0` (0 counts as 1).
- R3: With `cto_range` = 4'b0110, the same window applies with N = `tmo_val1`.
- R4: Any other `cto_range` value at request time starts no timer, so no report is ever produced for that request.
- R5: While `cap_disable_ok` is 0, `cto_disable` has no effect and timers start and expire as usual.
- R6: While `cap_disable_ok` and `cto_disable` are both 1, no timer starts, and all active timers and unsent reports are dropped.
- R7: A report has `rpt_desc` bits [15:12] = 4'b1001, bit 30 = 1, bits [71:64] = tag (zero-extended), bits [55:48] = requester function, and every other bit 0. `rpt_desc` is all zero while `rpt_valid` is 0, including after reset.
- R8: A completion whose `cpl_tag` has an active timer cancels it, so no report is produced. A completion for a tag with no active timer is ignored.
- R9: A completion that arrives in the same cycle as its tag's final tick wins, and no report is issued.
- R10: Expired tags are reported one per accepted handshake (`rpt_valid` and `rpt_ready` both 1), lowest tag first. `rpt_valid` stays high while `rpt_ready` is low.
- R11: Reissuing a request on an active tag restarts its full period and replaces the recorded function.
- R12: Changing `cto_range`, `tmo_val0` or `tmo_val1` after a request has started does not alter that request's timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request issued this cycle |
| req_tag | input | TAG_W | Tag of the issued request |
| req_func | input | 8 | Requester function number |
| req_type | input | 2 | 0 memory, 1 I/O, 2 configuration, 3 atomic |
| cpl_valid | input | 1 | Completion received this cycle |
| cpl_tag | input | TAG_W | Tag of the received completion |
| cto_range | input | 4 | Timeout range selection field |
| cto_disable | input | 1 | Timeout disable control bit |
| cap_disable_ok | input | 1 | Strap that allows the disable bit to act |
| tmo_val0 | input | CNT_W | Period in ticks for range 4'b0101 |
| tmo_val1 | input | CNT_W | Period in ticks for range 4'b0110 |
| rpt_valid | output | 1 | Timeout descriptor available |
| rpt_ready | input | 1 | Consumer accepts the descriptor |
| rpt_desc | output | 96 | Timeout completion descriptor |

## Verification
The hardest case to reach from the ports is a completion that lands on the exact edge where its tag's last tick fires. The prescaler phase cannot be seen directly, so the bench first runs one timeout and records the edge where the report appears, which must be a tick edge. It then uses that phase to issue a one-tick request just before a tick edge and sends the completion on that tick edge. A control run with the same alignment and no completion shows that the report would otherwise appear on exactly that edge.

// File: rtl/cto_pkg.sv
package cto_pkg;
  localparam int DESC_W  = 96;
  localparam int FUNC_W  = 8;
  localparam logic [3:0] RANGE_SEL0 = 4'b0101;
  localparam logic [3:0] RANGE_SEL1 = 4'b0110;
  localparam logic [3:0] TMO_STATUS = 4'b1001;

  typedef enum logic [1:0] {
    RQ_MEM    = 2'd0,
    RQ_IO     = 2'd1,
    RQ_CFG    = 2'd2,
    RQ_ATOMIC = 2'd3
  } rq_kind_e;
endpackage

// File: rtl/cto_tick.sv
module cto_tick #(
  parameter int PRESCALE = 4,
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == PW'(PRESCALE - 1));
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (PRESCALE > 1) begin : g_gap
      // R2: ticks are spaced, never back to back
      a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/cto_slot.sv
module cto_slot #(
  parameter int FUNC_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              clr,
  input  logic              start,
  input  logic [FUNC_W-1:0] start_func,
  input  logic [CNT_W-1:0]  start_period,
  input  logic              cpl_hit,
  input  logic              rel,
  output logic              pend,
  output logic [FUNC_W-1:0] func
);
  logic              act_q, act_d;
  logic              pend_q, pend_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [FUNC_W-1:0] func_q, func_d;
  logic              en;
  logic              last_tick;

  always_comb begin
    act_d     = act_q;
    pend_d    = pend_q;
    cnt_d     = cnt_q;
    func_d    = func_q;
    last_tick = act_q && tick && (cnt_q <= CNT_W'(1));
    if (clr) begin
      act_d  = 1'b0;
      pend_d = 1'b0;
    end else if (start) begin
      act_d  = 1'b1;
      pend_d = 1'b0;
      cnt_d  = (start_period == '0) ? CNT_W'(1) : start_period;
      func_d = start_func;
    end else begin
      if (cpl_hit && act_q) begin
        act_d = 1'b0;
      end else if (last_tick) begin
        act_d  = 1'b0;
        pend_d = 1'b1;
      end else if (act_q && tick) begin
        cnt_d = cnt_q - 1'b1;
      end
      if (rel) pend_d = 1'b0;
    end
    en = clr || start || (cpl_hit && act_q) || (act_q && tick) || rel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      func_q <= '0;
    end else if (en) begin
      act_q  <= act_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      func_q <= func_d;
    end
  end

  assign pend = pend_q;
  assign func = func_q;

  // R8: a completion on a running timer stops it
  a_r8_cpl_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_hit && act_q && !clr && !start) |=> !act_q);
  // R9: completion on the final tick suppresses the report
  a_r9_cpl_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_hit && act_q && tick && (cnt_q <= CNT_W'(1)) && !clr && !start) |=> !pend_q);
  // R6: effective disable drops timers and reports
  a_r6_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!act_q && !pend_q));
endmodule

// File: rtl/cto_pick.sv
module cto_pick #(
  parameter int N  = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/cpl_timeout_tracker.sv
module cpl_timeout_tracker
  import cto_pkg::*;
#(
  parameter int NTAGS    = 32,
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 4,
  localparam int TAG_W   = $clog2(NTAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [7:0]        req_func,
  input  logic [1:0]        req_type,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag,
  input  logic [3:0]        cto_range,
  input  logic              cto_disable,
  input  logic              cap_disable_ok,
  input  logic [CNT_W-1:0]  tmo_val0,
  input  logic [CNT_W-1:0]  tmo_val1,
  output logic              rpt_valid,
  input  logic              rpt_ready,
  output logic [95:0]       rpt_desc
);
  logic              tick;
  logic              dis_eff;
  logic              armed;
  logic              tracked;
  logic [CNT_W-1:0]  period;
  logic [NTAGS-1:0]  pend_vec;
  logic [FUNC_W-1:0] func_arr [NTAGS];
  logic              any;
  logic [TAG_W-1:0]  pick_idx;
  logic              ack;

  always_comb begin
    dis_eff = cap_disable_ok && cto_disable;
    armed   = ((cto_range == RANGE_SEL0) || (cto_range == RANGE_SEL1)) && !dis_eff;
    tracked = req_valid && (req_type != RQ_CFG) && armed;
    period  = (cto_range == RANGE_SEL1) ? tmo_val1 : tmo_val0;
    ack     = any && rpt_ready;
  end

  cto_tick #(.PRESCALE(PRESCALE)) i_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  generate
    for (genvar g = 0; g < NTAGS; g++) begin : g_slot
      cto_slot #(.FUNC_W(FUNC_W), .CNT_W(CNT_W)) i_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .clr         (dis_eff),
        .start       (tracked && (req_tag == TAG_W'(g))),
        .start_func  (req_func),
        .start_period(period),
        .cpl_hit     (cpl_valid && (cpl_tag == TAG_W'(g))),
        .rel         (ack && (pick_idx == TAG_W'(g))),
        .pend        (pend_vec[g]),
        .func        (func_arr[g])
      );
    end
  endgenerate

  cto_pick #(.N(NTAGS)) i_pick (
    .pend(pend_vec),
    .any (any),
    .idx (pick_idx)
  );

  always_comb begin
    rpt_desc = '0;
    if (any) begin
      rpt_desc[15:12] = TMO_STATUS;
      rpt_desc[30]    = 1'b1;
      rpt_desc[71:64] = 8'(pick_idx);
      rpt_desc[55:48] = func_arr[pick_idx];
    end
    rpt_valid = any;
  end

  // R10: an unaccepted report is held
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_ready && !dis_eff && !req_valid) |=> rpt_valid);
endmodule

// File: tb/test_cpl_timeout_tracker.sv
module test_cpl_timeout_tracker;
  localparam int P     = 4;
  localparam int CNT_W = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, cpl_valid, cto_disable, cap_disable_ok, rpt_valid, rpt_ready;
  logic [4:0]  req_tag, cpl_tag;
  logic [7:0]  req_func;
  logic [1:0]  req_type;
  logic [3:0]  cto_range;
  logic [CNT_W-1:0] tmo_val0, tmo_val1;
  logic [95:0] rpt_desc;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int tick_cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cpl_timeout_tracker #(.NTAGS(32), .CNT_W(CNT_W), .PRESCALE(P)) i_cpl_timeout_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag), .req_func(req_func),
    .req_type(req_type), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cto_range(cto_range),
    .cto_disable(cto_disable), .cap_disable_ok(cap_disable_ok), .tmo_val0(tmo_val0),
    .tmo_val1(tmo_val1), .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_desc(rpt_desc)
  );

  task automatic check(input bit ok, input string r, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic logic [95:0] exp_desc(input int tag, input int func);
    logic [95:0] d = '0;
    d[15:12] = 4'b1001;
    d[30]    = 1'b1;
    d[71:64] = 8'(tag);
    d[55:48] = 8'(func);
    return d;
  endfunction

  // all tasks are entered and left at a falling edge
  task automatic issue(input int tag, input int func, input int typ);
    req_valid = 1'b1; req_tag = 5'(tag); req_func = 8'(func); req_type = 2'(typ);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic complete(input int tag);
    cpl_valid = 1'b1; cpl_tag = 5'(tag);
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic expect_quiet(input int n, input string r);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      if (rpt_valid) seen = 1;
      @(negedge clk);
    end
    check(!seen, r, 96'(seen), 96'(0));
  endtask

  // issue a request and check the report lands in the window for n ticks
  task automatic run_window(input int tag, input int func, input int n, input bit perturb, input string r);
    int m = 0;
    bit seen = 0;
    issue(tag, func, 0);
    if (perturb) begin cto_range = 4'b0000; tmo_val0 = 16'd50; tmo_val1 = 16'd50; end
    while (m <= n * P + 2 && !seen) begin
      if (rpt_valid) begin
        seen = 1;
        tick_cyc = cyc;
        check(rpt_desc == exp_desc(tag, func), r, rpt_desc, exp_desc(tag, func));
      end else begin
        @(negedge clk);
        m++;
      end
    end
    check(seen && m > (n - 1) * P && m <= n * P, r, 96'(m), 96'(n * P));
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(rpt_valid == 1'b0 && rpt_desc == '0, "R7", {95'(0), rpt_valid}, 96'(0));
  endtask

  task automatic t_range0();
    cto_range = 4'b0101; tmo_val0 = 16'd3; tmo_val1 = 16'd6;
    run_window(7, 8'h5A, 3, 0, "R2");
  endtask

  task automatic t_range1();
    cto_range = 4'b0110;
    run_window(2, 8'hC3, 6, 0, "R3");
    cto_range = 4'b0101;
  endtask

  task automatic t_cfg();
    issue(3, 8'h01, 2);
    expect_quiet(40, "R1");
    run_window(3, 8'h01, 3, 0, "R1");
  endtask

  task automatic t_inert();
    cto_range = 4'b0000; issue(4, 1, 0);
    cto_range = 4'b1010; issue(5, 1, 1);
    cto_range = 4'b0111; issue(6, 1, 3);
    expect_quiet(60, "R4");
    cto_range = 4'b0101;
  endtask

  task automatic t_no_cap();
    cap_disable_ok = 1'b0; cto_disable = 1'b1;
    run_window(8, 8'h33, 3, 0, "R5");
    cto_disable = 1'b0;
  endtask

  task automatic t_disable();
    cap_disable_ok = 1'b1; tmo_val0 = 16'd20;
    issue(4, 8'h44, 0);
    repeat (5) @(negedge clk);
    cto_disable = 1'b1;
    expect_quiet(100, "R6");
    issue(5, 8'h45, 0);
    expect_quiet(100, "R6");
    cto_disable = 1'b0;
    expect_quiet(100, "R6");
    cap_disable_ok = 1'b0; tmo_val0 = 16'd3;
  endtask

  task automatic t_cancel();
    tmo_val0 = 16'd5;
    issue(9, 8'h09, 0);
    repeat (3) @(negedge clk);
    complete(9);
    expect_quiet(40, "R8");
    complete(12);
    run_window(11, 8'h0B, 5, 0, "R8");
    tmo_val0 = 16'd3;
  endtask

  task automatic t_race();
    tmo_val0 = 16'd1;
    while ((cyc + 2 - tick_cyc) % P != 0) @(negedge clk);
    issue(15, 8'h0F, 0);
    complete(15);
    expect_quiet(20, "R9");
    while ((cyc + 2 - tick_cyc) % P != 0) @(negedge clk);
    issue(16, 8'h10, 0);
    @(negedge clk);
    check(rpt_valid && rpt_desc == exp_desc(16, 8'h10), "R9", rpt_desc, exp_desc(16, 8'h10));
    @(negedge clk);
    tmo_val0 = 16'd3;
  endtask

  task automatic t_order();
    tmo_val0 = 16'd2; rpt_ready = 1'b0;
    issue(20, 8'hA0, 0);
    issue(3, 8'hA1, 1);
    issue(17, 8'hA2, 3);
    repeat (30) @(negedge clk);
    check(rpt_valid && rpt_desc == exp_desc(3, 8'hA1), "R10", rpt_desc, exp_desc(3, 8'hA1));
    rpt_ready = 1'b1;
    @(negedge clk);
    check(rpt_valid && rpt_desc == exp_desc(17, 8'hA2), "R10", rpt_desc, exp_desc(17, 8'hA2));
    @(negedge clk);
    check(rpt_valid && rpt_desc == exp_desc(20, 8'hA0), "R10", rpt_desc, exp_desc(20, 8'hA0));
    @(negedge clk);
    check(!rpt_valid, "R10", {95'(0), rpt_valid}, 96'(0));
    tmo_val0 = 16'd3;
  endtask

  task automatic t_reissue();
    tmo_val0 = 16'd4;
    issue(13, 8'h11, 0);
    repeat (12) @(negedge clk);
    run_window(13, 8'h22, 4, 0, "R11");
    tmo_val0 = 16'd3;
  endtask

  task automatic t_late_change();
    cto_range = 4'b0101; tmo_val0 = 16'd4;
    run_window(14, 8'h77, 4, 1, "R12");
    cto_range = 4'b0101; tmo_val0 = 16'd3; tmo_val1 = 16'd6;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; cpl_valid = 1'b0; req_tag = '0; cpl_tag = '0;
    req_func = '0; req_type = '0; cto_range = 4'b0101; cto_disable = 1'b0;
    cap_disable_ok = 1'b0; tmo_val0 = 16'd3; tmo_val1 = 16'd6; rpt_ready = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_range0();
    t_range1();
    t_cfg();
    t_inert();
    t_no_cap();
    t_disable();
    t_cancel();
    t_race();
    t_order();
    t_reissue();
    t_late_change();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule